// File: doc/BRIEF.md
# Ternary Match Table with Priority Select

This block is a small ternary lookup table. It holds a parameterised number of entries, each made of a row of ternary digits. Each digit can be zero, one or "any", and is kept as a pair of bits. A write port loads one entry together with an action word, or invalidates that entry.

A search presents a key together with a per-bit mask. A mask bit at 1 turns that key bit into a wildcard. The key is compared against every valid entry at the same time, which yields one match flag per entry. A priority selector then picks the lowest-numbered matching entry. Entries are expected to be loaded most-important first, so the lowest number is the most important. The winning number reads the action store, which returns, for example, a next-hop or output-port code.

The result is registered. One clock after a search request the block presents a response strobe, a hit or miss flag, the match flags of all entries, the winning index and its action word.

Top module: `tcam_lookup`

## Requirements
- R1: After reset every entry is invalid. `rsp_valid_o`, `hit_o`, `miss_o` and `match_vec_o` are 0, and a search of the empty table reports a miss.
- R2: Digit i of an entry is written as the bit pair (`wr_d1_i[i]`, `wr_d0_i[i]`). Zero is d1=1,d0=0 and one is d1=0,d0=1. An entry made only of zero and one digits matches exactly the key equal to its value.
- R3: A stored "any" digit (d1=1,d0=1) matches a key bit of either value.
- R4: Setting `key_mask_i[i]`=1 makes key bit i match any zero, one or "any" digit stored in that position.
- R5: A single mismatching digit makes its entry miss.
- R6: An entry holding any digit with d1=0,d0=0 never matches, even when every key bit is masked.
- R7: Bit n of `match_vec_o` is 1 exactly when entry n matched. All entries are evaluated in the same search.
- R8: When several entries match, `idx_o` is the lowest-numbered matching entry.
- R9: `act_o` is the action word last written with the winning entry.
- R10: The results appear in the cycle after `srch_en_i` is high, with `rsp_valid_o`=1. Exactly one of `hit_o`/`miss_o` is set. On a miss, `idx_o`, `act_o` and `match_vec_o` are 0. In cycles with no response, all result outputs are 0.
- R11: A write with `wr_clear_i`=1 invalidates the addressed entry, so that entry no longer matches.
- R12: A write, load or clear, issued in the same cycle as a search does not affect that search. It is seen from the next search onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_clear_i | input | 1 | With wr_en_i: invalidate entry instead of loading |
| wr_idx_i | input | IDX_W | Entry number to write |
| wr_d0_i | input | KEY_W | Low bit of each digit |
| wr_d1_i | input | KEY_W | High bit of each digit |
| wr_act_i | input | ACT_W | Action word stored with the entry |
| srch_en_i | input | 1 | Search request |
| key_i | input | KEY_W | Search key |
| key_mask_i | input | KEY_W | 1 = key bit is a wildcard |
| rsp_valid_o | output | 1 | Search response strobe |
| hit_o | output | 1 | At least one entry matched |
| miss_o | output | 1 | No entry matched |
| idx_o | output | IDX_W | Winning entry number |
| act_o | output | ACT_W | Action word of the winning entry |
| match_vec_o | output | ENTRIES | Per-entry match flags |

## Verification
The bench builds the block with its defaults: 8 entries, 8-bit keys and 8-bit actions. This is enough to put exact, partly wildcarded and fully wildcarded entries side by side, and to have both the lowest entry (0) and the highest entry (7) win. Overlapping entries exercise the priority selection. Loads and clears are also issued in the same cycle as a search, to show that a search sees the table as it stood before the write.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  // digit code written as {d1,d0}
  typedef enum logic [1:0] {
    DIG_VOID = 2'b00,
    DIG_ONE  = 2'b01,
    DIG_ZERO = 2'b10,
    DIG_ANY  = 2'b11
  } digit_e;
endpackage

// File: rtl/tcam_row.sv
module tcam_row #(
  parameter int KEY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_clear_i,
  input  logic [KEY_W-1:0] wr_d0_i,
  input  logic [KEY_W-1:0] wr_d1_i,
  input  logic [KEY_W-1:0] sl_i,
  input  logic [KEY_W-1:0] slb_i,
  output logic             match_o
);
  logic [KEY_W-1:0] d0_q, d1_q;
  logic             valid_q;
  logic [KEY_W-1:0] dig_miss, dig_void;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d0_q    <= '0;
      d1_q    <= '0;
      valid_q <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_clear_i) begin
        d0_q    <= '0;
        d1_q    <= '0;
        valid_q <= 1'b0;
      end else begin
        d0_q    <= wr_d0_i;
        d1_q    <= wr_d1_i;
        valid_q <= 1'b1;
      end
    end
  end

  // pull-down per digit: driven line with no matching stored bit
  for (genvar i = 0; i < KEY_W; i++) begin : g_dig
    assign dig_miss[i] = (sl_i[i] & ~d0_q[i]) | (slb_i[i] & ~d1_q[i]);
    assign dig_void[i] = ({d1_q[i], d0_q[i]} == tcam_pkg::DIG_VOID);
  end

  assign match_o = valid_q & ~|dig_void & ~|dig_miss;

  a_r11_clear_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_clear_i |=> !match_o);
  a_r5_miss_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dig_miss) |-> !match_o);
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign found_o = |req_i;
endmodule

// File: rtl/tcam_act_mem.sv
module tcam_act_mem #(
  parameter int N     = 8,
  parameter int ACT_W = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [ACT_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ACT_W-1:0] rd_data_o
);
  logic [ACT_W-1:0] mem_q [N];

  for (genvar n = 0; n < N; n++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[n] <= '0;
      else if (we_i && wr_idx_i == IDX_W'(n))    mem_q[n] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 8,
  parameter int ACT_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_clear_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [KEY_W-1:0]   wr_d0_i,
  input  logic [KEY_W-1:0]   wr_d1_i,
  input  logic [ACT_W-1:0]   wr_act_i,
  input  logic               srch_en_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [KEY_W-1:0]   key_mask_i,
  output logic               rsp_valid_o,
  output logic               hit_o,
  output logic               miss_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [ACT_W-1:0]   act_o,
  output logic [ENTRIES-1:0] match_vec_o
);
  logic [KEY_W-1:0]   sl, slb;
  logic [ENTRIES-1:0] match_raw;
  logic               found;
  logic [IDX_W-1:0]   win_idx;
  logic [ACT_W-1:0]   win_act;

  // masked key bits drive neither search line
  assign sl  =  key_i & ~key_mask_i;
  assign slb = ~key_i & ~key_mask_i;

  for (genvar n = 0; n < ENTRIES; n++) begin : g_row
    tcam_row #(.KEY_W(KEY_W)) u_row (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i && wr_idx_i == IDX_W'(n)),
      .wr_clear_i (wr_clear_i),
      .wr_d0_i    (wr_d0_i),
      .wr_d1_i    (wr_d1_i),
      .sl_i       (sl),
      .slb_i      (slb),
      .match_o    (match_raw[n])
    );
  end

  tcam_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc (
    .req_i   (match_raw),
    .found_o (found),
    .idx_o   (win_idx)
  );

  tcam_act_mem #(.N(ENTRIES), .ACT_W(ACT_W), .IDX_W(IDX_W)) u_act (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en_i && !wr_clear_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_act_i),
    .rd_idx_i  (win_idx),
    .rd_data_o (win_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      miss_o      <= 1'b0;
      idx_o       <= '0;
      act_o       <= '0;
      match_vec_o <= '0;
    end else begin
      rsp_valid_o <= srch_en_i;
      hit_o       <= srch_en_i & found;
      miss_o      <= srch_en_i & ~found;
      idx_o       <= (srch_en_i && found) ? win_idx : '0;
      act_o       <= (srch_en_i && found) ? win_act : '0;
      match_vec_o <= srch_en_i ? match_raw : '0;
    end
  end

  a_r10_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_en_i |=> rsp_valid_o);
  a_r10_hit_xor_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (hit_o ^ miss_o));
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!hit_o && !miss_o && match_vec_o == '0));
  a_r10_miss_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (match_vec_o == '0 && idx_o == '0 && act_o == '0));
  a_r8_winner_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> match_vec_o[idx_o]);
  a_r8_none_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((match_vec_o & ((ENTRIES'(1) << idx_o) - ENTRIES'(1))) == '0));
endmodule

// File: tb/tcam_lookup_tb.sv
`timescale 1ns/1ps
module tcam_lookup_tb;
  localparam int N = 8, KW = 8, AW = 8, IW = 3;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          wr_en_i = 0, wr_clear_i = 0, srch_en_i = 0;
  logic [IW-1:0] wr_idx_i = '0;
  logic [KW-1:0] wr_d0_i = '0, wr_d1_i = '0, key_i = '0, key_mask_i = '0;
  logic [AW-1:0] wr_act_i = '0;
  logic          rsp_valid_o, hit_o, miss_o;
  logic [IW-1:0] idx_o;
  logic [AW-1:0] act_o;
  logic [N-1:0]  match_vec_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  tcam_lookup #(.ENTRIES(N), .KEY_W(KW), .ACT_W(AW)) u_dut (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // digit pairs for a value with a don't-care mask
  function automatic logic [2*KW-1:0] tern(logic [KW-1:0] v, logic [KW-1:0] dc);
    return {(~v | dc), (v | dc)};  // {d1, d0}
  endfunction

  task automatic load(int idx, logic [KW-1:0] v, logic [KW-1:0] dc, logic [AW-1:0] a);
    logic [2*KW-1:0] t = tern(v, dc);
    @(negedge clk_i);
    wr_en_i = 1; wr_clear_i = 0; wr_idx_i = IW'(idx);
    wr_d1_i = t[2*KW-1:KW]; wr_d0_i = t[KW-1:0]; wr_act_i = a;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic load_raw(int idx, logic [KW-1:0] d1, logic [KW-1:0] d0, logic [AW-1:0] a);
    @(negedge clk_i);
    wr_en_i = 1; wr_clear_i = 0; wr_idx_i = IW'(idx);
    wr_d1_i = d1; wr_d0_i = d0; wr_act_i = a;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic clear(int idx);
    @(negedge clk_i);
    wr_en_i = 1; wr_clear_i = 1; wr_idx_i = IW'(idx);
    @(negedge clk_i);
    wr_en_i = 0; wr_clear_i = 0;
  endtask

  task automatic search(logic [KW-1:0] k, logic [KW-1:0] m);
    @(negedge clk_i);
    srch_en_i = 1; key_i = k; key_mask_i = m;
    @(negedge clk_i);
    srch_en_i = 0;
  endtask

  task automatic expect_res(string req, logic [N-1:0] vec, logic h, int idx, logic [AW-1:0] a);
    chk(req, "rsp_valid", rsp_valid_o, 1);
    chk(req, "match_vec", match_vec_o, vec);
    chk(req, "hit", hit_o, h);
    chk(req, "miss", miss_o, !h);
    chk(req, "idx", idx_o, idx);
    chk(req, "act", act_o, a);
  endtask

  task automatic t_reset();
    chk("R1", "rsp_valid", rsp_valid_o, 0);
    chk("R1", "hit", hit_o, 0);
    chk("R1", "miss", miss_o, 0);
    chk("R1", "match_vec", match_vec_o, 0);
    search(8'h00, 8'hFF);
    expect_res("R1", 8'h00, 0, 0, 0);
  endtask

  task automatic t_exact();
    load(3, 8'hA5, 8'h00, 8'h33);
    search(8'hA5, 8'h00);
    expect_res("R2", 8'h08, 1, 3, 8'h33);
    search(8'hA4, 8'h00);
    expect_res("R5", 8'h00, 0, 0, 0);
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    chk("R10", "idle rsp_valid", rsp_valid_o, 0);
    chk("R10", "idle hit", hit_o, 0);
    chk("R10", "idle miss", miss_o, 0);
  endtask

  task automatic t_stored_any();
    load(5, 8'h50, 8'h0F, 8'h55);
    search(8'h5C, 8'h00);
    expect_res("R3", 8'h20, 1, 5, 8'h55);
    search(8'h53, 8'h00);
    expect_res("R3", 8'h20, 1, 5, 8'h55);
  endtask

  task automatic t_key_mask();
    search(8'hA0, 8'h0F);
    expect_res("R4", 8'h08, 1, 3, 8'h33);
    search(8'h00, 8'hFF);
    expect_res("R7", 8'h28, 1, 3, 8'h33);
  endtask

  task automatic t_void();
    load_raw(1, 8'hFE, 8'h00, 8'h11);  // bit0 digit is 00
    search(8'h00, 8'hFF);
    expect_res("R6", 8'h28, 1, 3, 8'h33);
  endtask

  task automatic t_priority();
    load(2, 8'h00, 8'hFF, 8'h22);
    search(8'hA5, 8'h00);
    expect_res("R8", 8'h0C, 1, 2, 8'h22);
    search(8'h5F, 8'h00);
    expect_res("R9", 8'h24, 1, 2, 8'h22);
  endtask

  task automatic t_clear();
    clear(2);
    search(8'hA5, 8'h00);
    expect_res("R11", 8'h08, 1, 3, 8'h33);
  endtask

  task automatic t_collide();
    // load in same cycle as search
    @(negedge clk_i);
    srch_en_i = 1; key_i = 8'h77; key_mask_i = 8'h00;
    wr_en_i = 1; wr_clear_i = 0; wr_idx_i = 3'd0;
    {wr_d1_i, wr_d0_i} = tern(8'h77, 8'h00); wr_act_i = 8'h44;
    @(negedge clk_i);
    srch_en_i = 0; wr_en_i = 0;
    expect_res("R12", 8'h00, 0, 0, 0);
    search(8'h77, 8'h00);
    expect_res("R12", 8'h01, 1, 0, 8'h44);
    // clear in same cycle as search
    @(negedge clk_i);
    srch_en_i = 1; key_i = 8'h77;
    wr_en_i = 1; wr_clear_i = 1; wr_idx_i = 3'd0;
    @(negedge clk_i);
    srch_en_i = 0; wr_en_i = 0; wr_clear_i = 0;
    expect_res("R12", 8'h01, 1, 0, 8'h44);
    search(8'h77, 8'h00);
    expect_res("R11", 8'h00, 0, 0, 0);
  endtask

  task automatic t_top_entry();
    load(7, 8'h00, 8'hFF, 8'h77);
    search(8'h12, 8'h00);
    expect_res("R8", 8'h80, 1, 7, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_exact();
    t_idle();
    t_stored_any();
    t_key_mask();
    t_void();
    t_priority();
    t_clear();
    t_collide();
    t_top_entry();
    t_idle();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule